// File: doc/BRIEF.md
# EPROM Fast Programming Sequencer

This block writes a word-wide one-time-programmable memory one address at a time. It raises the two elevated programming supplies and waits for them to settle. For each word it drives address and data, fires an active-low program strobe, then reads the word back. If the read-back does not match, it fires another strobe. A word that still mismatches after the pulse limit fails the device. So does a word whose read-back shows a 0 where the target needs a 1, because programming can only clear bits.

After the last word verifies, the sequencer drops the supplies back to read levels and waits for them to settle. It then reads every word once more. A single mismatch marks the device failed; otherwise it is passed.

The host supplies a start strobe and a combinational word source: the block presents an address and the host returns the target data. All microsecond timings are derived from a clock-frequency parameter. `done_o` pulses for one cycle at the end of a run. `pass_o` and `fail_o` then hold until the next start.

Top module: `eprom_prog_seq`

## Requirements
- R1: Out of reset and while idle, chip-enable, output-enable and program strobes are high, the data bus is not driven, both supply selects are low, and done, pass and fail are 0.
- R2: Both supply selects are high during every program pulse and at least SETTLE_CYC cycles before the first one. They are low for at least SETTLE_CYC cycles before the first read of the final pass.
- R3: Every program pulse lasts exactly CLK_MHZ*PULSE_US cycles, with chip-enable low and output-enable high.
- R4: Address, data and output-enable high are stable with the bus driven for at least CLK_MHZ*SETUP_US cycles before each pulse falls. Data stays driven for at least CLK_MHZ*HOLD_US cycles after it rises. The bus is never driven while output-enable is low.
- R5: Each start begins at address 0 with a cleared pulse count. A word whose cells take k pulses (k at most MAX_PULSES) receives exactly k pulses before the address advances.
- R6: A word still mismatching after MAX_PULSES pulses ends the run with fail. No later address receives a pulse.
- R7: If a read-back holds 0 in any bit where the target holds 1, the run ends with fail at once, with no further pulse.
- R8: After the last address verifies, every word is read back at normal supply levels. Any mismatch gives fail; otherwise the run gives pass.
- R9: `done_o` is high for exactly one cycle per run. In that cycle exactly one of `pass_o` and `fail_o` is 1, and both hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken while idle |
| src_addr_o | output | ADDR_W | Word address presented to the host source |
| src_data_i | input | DATA_W | Target word for `src_addr_o` |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Device passed |
| fail_o | output | 1 | Device failed |
| dev_addr_o | output | ADDR_W | Memory address |
| dev_data_o | output | DATA_W | Data driven to the memory |
| dev_drive_o | output | 1 | Data bus drive enable |
| dev_data_i | input | DATA_W | Read-back data from the memory |
| dev_ce_no | output | 1 | Chip enable, active low |
| dev_oe_no | output | 1 | Output enable, active low |
| dev_pgm_no | output | 1 | Program strobe, active low |
| vpp_hi_o | output | 1 | Select elevated program supply |
| vcc_hi_o | output | 1 | Select elevated core supply |

## Verification
Every device-side output decodes straight from the state register, so each phase edge appears one clock after the timer that ends it expires. Pulse width, setup, hold and settle spans are therefore exact cycle counts. The bench measures them on falling-edge samples as runs of consecutive cycles, starting from the sample where a line first changes. The read-back is sampled at the end of a READ_CYC-cycle window. `done_o` appears in the cycle after that final compare, so the bench waits sample by sample for `done_o` and reads pass and fail in that same sample. Pulse counts and memory contents are checked only after the run ends, and result stability is rechecked 40 cycles later.

// File: rtl/eps_pkg.sv
package eps_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RAMP, ST_SETUP, ST_PULSE, ST_HOLD,
    ST_VERIFY, ST_DROP, ST_FINAL, ST_DONE
  } eps_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/eps_timer.sv
module eps_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= value_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/eps_counters.sv
module eps_counters #(
  parameter int ADDR_W     = 16,
  parameter int MAX_PULSES = 25,
  localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_clr_i,
  input  logic              addr_inc_i,
  input  logic              pulse_clr_i,
  input  logic              pulse_inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              at_max_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= '0;
    else if (addr_clr_i) addr_q <= '0;
    else if (addr_inc_i) addr_q <= addr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pulse_q <= '0;
    else if (pulse_clr_i) pulse_q <= '0;
    else if (pulse_inc_i) pulse_q <= pulse_q + 1'b1;
  end

  assign addr_o   = addr_q;
  assign last_o   = (addr_q == '1);
  assign at_max_o = (pulse_q >= CNT_W'(MAX_PULSES));
endmodule

// File: rtl/eps_cmp.sv
module eps_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] target_i,
  input  logic [DATA_W-1:0] read_i,
  output logic              match_o,
  output logic              bad_zero_o
);
  assign match_o    = (target_i == read_i);
  // a cleared cell cannot be set again
  assign bad_zero_o = |(target_i & ~read_i);
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eps_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int CLK_MHZ    = 50,
  parameter int SETUP_US   = 2,
  parameter int HOLD_US    = 2,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25,
  parameter int SETTLE_CYC = 100,
  parameter int READ_CYC   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [DATA_W-1:0] dev_data_o,
  output logic              dev_drive_o,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic              dev_ce_no,
  output logic              dev_oe_no,
  output logic              dev_pgm_no,
  output logic              vpp_hi_o,
  output logic              vcc_hi_o
);
  localparam int SETUP_CYC = imax(1, CLK_MHZ * SETUP_US);
  localparam int HOLD_CYC  = imax(1, CLK_MHZ * HOLD_US);
  localparam int PULSE_CYC = imax(1, CLK_MHZ * PULSE_US);
  localparam int SETTLE_C  = imax(1, SETTLE_CYC);
  localparam int READ_C    = imax(1, READ_CYC);
  localparam int MAX_T     = imax(imax(imax(SETUP_CYC, HOLD_CYC), imax(PULSE_CYC, SETTLE_C)), READ_C);
  localparam int TMR_W     = imax(1, $clog2(MAX_T + 1));

  localparam logic [TMR_W-1:0] LD_SETUP  = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] LD_HOLD   = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] LD_PULSE  = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] LD_SETTLE = TMR_W'(SETTLE_C - 1);
  localparam logic [TMR_W-1:0] LD_READ   = TMR_W'(READ_C - 1);

  eps_state_e state_q, state_d;

  logic             tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic             addr_clr, addr_inc, pulse_clr, pulse_inc;
  logic             last, at_max, match, bad_zero;
  logic             set_pass, set_fail, clr_res;
  logic             pass_q, fail_q;
  logic [ADDR_W-1:0] addr;

  eps_timer #(.W(TMR_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .value_i(tmr_val), .expired_o(tmr_exp)
  );

  eps_counters #(.ADDR_W(ADDR_W), .MAX_PULSES(MAX_PULSES)) u_cnt (
    .clk_i, .rst_ni,
    .addr_clr_i(addr_clr), .addr_inc_i(addr_inc),
    .pulse_clr_i(pulse_clr), .pulse_inc_i(pulse_inc),
    .addr_o(addr), .last_o(last), .at_max_o(at_max)
  );

  eps_cmp #(.DATA_W(DATA_W)) u_cmp (
    .target_i(src_data_i), .read_i(dev_data_i),
    .match_o(match), .bad_zero_o(bad_zero)
  );

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    addr_clr  = 1'b0;
    addr_inc  = 1'b0;
    pulse_clr = 1'b0;
    pulse_inc = 1'b0;
    set_pass  = 1'b0;
    set_fail  = 1'b0;
    clr_res   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RAMP; tmr_load = 1'b1; tmr_val = LD_SETTLE;
        addr_clr = 1'b1; pulse_clr = 1'b1; clr_res = 1'b1;
      end
      ST_RAMP: if (tmr_exp) begin
        state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = LD_SETUP;
      end
      ST_SETUP: if (tmr_exp) begin
        state_d = ST_PULSE; tmr_load = 1'b1; tmr_val = LD_PULSE; pulse_inc = 1'b1;
      end
      ST_PULSE: if (tmr_exp) begin
        state_d = ST_HOLD; tmr_load = 1'b1; tmr_val = LD_HOLD;
      end
      ST_HOLD: if (tmr_exp) begin
        state_d = ST_VERIFY; tmr_load = 1'b1; tmr_val = LD_READ;
      end
      ST_VERIFY: if (tmr_exp) begin
        if (match) begin
          tmr_load = 1'b1;
          if (last) begin
            state_d = ST_DROP; tmr_val = LD_SETTLE;
          end else begin
            state_d = ST_SETUP; tmr_val = LD_SETUP;
            addr_inc = 1'b1; pulse_clr = 1'b1;
          end
        end else if (bad_zero || at_max) begin
          state_d = ST_DONE; set_fail = 1'b1;
        end else begin
          state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = LD_SETUP;
        end
      end
      ST_DROP: if (tmr_exp) begin
        state_d = ST_FINAL; tmr_load = 1'b1; tmr_val = LD_READ; addr_clr = 1'b1;
      end
      ST_FINAL: if (tmr_exp) begin
        if (!match) begin
          state_d = ST_DONE; set_fail = 1'b1;
        end else if (last) begin
          state_d = ST_DONE; set_pass = 1'b1;
        end else begin
          tmr_load = 1'b1; tmr_val = LD_READ; addr_inc = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (clr_res) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (set_pass) pass_q <= 1'b1;
      if (set_fail) fail_q <= 1'b1;
    end
  end

  logic prog_phase;
  assign prog_phase = (state_q == ST_RAMP) || (state_q == ST_SETUP) || (state_q == ST_PULSE) ||
                      (state_q == ST_HOLD) || (state_q == ST_VERIFY);

  assign src_addr_o  = addr;
  assign dev_addr_o  = addr;
  assign dev_data_o  = src_data_i;
  assign dev_drive_o = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);
  assign dev_ce_no   = !(dev_drive_o || (state_q == ST_VERIFY) || (state_q == ST_FINAL));
  assign dev_oe_no   = !((state_q == ST_VERIFY) || (state_q == ST_FINAL));
  assign dev_pgm_no  = (state_q != ST_PULSE);
  assign vpp_hi_o    = prog_phase;
  assign vcc_hi_o    = prog_phase;
  assign done_o      = (state_q == ST_DONE);
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;
endmodule

// File: rtl/eps_chk.sv
module eps_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] dev_addr_o,
  input logic [DATA_W-1:0] dev_data_o,
  input logic              dev_drive_o,
  input logic              dev_ce_no,
  input logic              dev_oe_no,
  input logic              dev_pgm_no,
  input logic              vpp_hi_o,
  input logic              vcc_hi_o
);
  // R3
  pulse_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_pgm_no |-> (!dev_ce_no && dev_oe_no && dev_drive_o));

  // R2
  pulse_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_pgm_no |-> (vpp_hi_o && vcc_hi_o));

  // R4
  pulse_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_pgm_no && !$past(dev_pgm_no)) |-> ($stable(dev_addr_o) && $stable(dev_data_o)));

  // R4
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_oe_no |-> !dev_drive_o);

  // R2
  supply_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vpp_hi_o) |-> (dev_oe_no && dev_pgm_no));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  result_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

  // R9
  result_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pass_o) || $rose(fail_o)) |-> done_o);
endmodule

bind eprom_prog_seq eps_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eps_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
  .dev_addr_o(dev_addr_o), .dev_data_o(dev_data_o), .dev_drive_o(dev_drive_o),
  .dev_ce_no(dev_ce_no), .dev_oe_no(dev_oe_no), .dev_pgm_no(dev_pgm_no),
  .vpp_hi_o(vpp_hi_o), .vcc_hi_o(vcc_hi_o)
);

// File: tb/eprom_prog_seq_test.sv
`timescale 1ns/1ps
module eprom_prog_seq_test;
  localparam int AW = 3, DW = 16, NW = 8;
  localparam int MHZ = 1, SETTLE = 10, RD = 3, MAXP = 25;
  localparam int SETUP = 2 * MHZ, HOLD = 2 * MHZ, PULSE = 100 * MHZ;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] src_addr, dev_addr;
  logic [DW-1:0] src_data, dev_data, rd_data;
  logic done, pass, fail, drive, ce_n, oe_n, pgm_n, vpp, vcc;

  always #2.5 clk = ~clk;

  eprom_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ), .SETUP_US(2), .HOLD_US(2),
    .PULSE_US(100), .MAX_PULSES(MAXP), .SETTLE_CYC(SETTLE), .READ_CYC(RD)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_addr_o(src_addr), .src_data_i(src_data),
    .done_o(done), .pass_o(pass), .fail_o(fail),
    .dev_addr_o(dev_addr), .dev_data_o(dev_data), .dev_drive_o(drive),
    .dev_data_i(rd_data), .dev_ce_no(ce_n), .dev_oe_no(oe_n), .dev_pgm_no(pgm_n),
    .vpp_hi_o(vpp), .vcc_hi_o(vcc)
  );

  function automatic logic [15:0] tgt(int a);
    return 16'h5AC3 ^ 16'(a * 16'h1F07);
  endfunction

  // behavioural memory: word a takes need[a] pulses; weak word misreads at normal supply
  logic [DW-1:0] mem [NW];
  int need [NW];
  int pc [NW];
  logic weak_en = 1'b0;
  logic [AW-1:0] weak_a = '0;

  assign src_data = tgt(int'(src_addr));
  assign rd_data  = mem[dev_addr] ^ ((weak_en && !vcc && dev_addr == weak_a) ? 16'h0010 : 16'h0000);

  int checks = 0, errors = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor state
  logic prev_pgm = 1'b1, prev_drive = 1'b0, prev_oe = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_data = '0;
  int stable_cnt, low_cnt, hold_cnt, sup_up, sup_dn;
  int width_err, setup_err, hold_err, sup_err, fv_err, fv_seen, done_cnt, pulses;
  bit hold_watch;

  always @(negedge clk) if (rst_n) begin
    automatic bit changed = (dev_addr != prev_addr) || (dev_data != prev_data) ||
                            (drive != prev_drive) || (oe_n != prev_oe);
    if (vpp && vcc) sup_up++; else sup_up = 0;
    if (!vpp && !vcc) sup_dn++; else sup_dn = 0;
    if (changed) stable_cnt = 0;
    if (pgm_n) begin
      if (drive && oe_n && !ce_n) stable_cnt++; else stable_cnt = 0;
    end
    if (!pgm_n && prev_pgm) begin
      if (stable_cnt < SETUP) setup_err++;
      if (sup_up < SETTLE) sup_err++;
      low_cnt = 0;
      pulses++;
    end
    if (!pgm_n) low_cnt++;
    if (pgm_n && !prev_pgm) begin
      if (low_cnt != PULSE) width_err++;
      pc[dev_addr]++;
      if (pc[dev_addr] >= need[dev_addr]) mem[dev_addr] = mem[dev_addr] & dev_data;
      hold_watch = 1'b1;
      hold_cnt = 0;
    end
    if (hold_watch) begin
      if (drive && pgm_n) hold_cnt++;
      else begin
        if (hold_cnt < HOLD) hold_err++;
        hold_watch = 1'b0;
      end
    end
    if (!oe_n && prev_oe && !vpp) begin
      fv_seen++;
      if (sup_dn < SETTLE) fv_err++;
    end
    if (done) done_cnt++;
    prev_pgm = pgm_n; prev_drive = drive; prev_oe = oe_n;
    prev_addr = dev_addr; prev_data = dev_data;
  end

  task automatic fresh_device();
    for (int a = 0; a < NW; a++) begin
      mem[a] = 16'hFFFF;
      need[a] = 1;
    end
    weak_en = 1'b0;
  endtask

  task automatic run(string name, bit exp_pass);
    int n;
    for (int a = 0; a < NW; a++) pc[a] = 0;
    stable_cnt = 0; low_cnt = 0; hold_cnt = 0; hold_watch = 1'b0;
    width_err = 0; setup_err = 0; hold_err = 0; sup_err = 0;
    fv_err = 0; fv_seen = 0; done_cnt = 0; pulses = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!done && n < 30000) begin
      @(negedge clk);
      n++;
    end
    check(n < 30000, {name, " watchdog"}, n, 30000);
    // R9 result valid with done; R8 outcome
    check(pass == exp_pass, {name, " R8 pass"}, int'(pass), int'(exp_pass));
    check(fail == !exp_pass, {name, " R9 fail"}, int'(fail), int'(!exp_pass));
    repeat (40) @(negedge clk);
    check(done_cnt == 1, {name, " R9 done width"}, done_cnt, 1);
    check(pass == exp_pass && fail == !exp_pass, {name, " R9 result held"},
          int'({pass, fail}), int'({exp_pass, !exp_pass}));
    check(width_err == 0 && pulses > 0, {name, " R3 pulse width"}, width_err, 0);
    check(setup_err == 0, {name, " R4 setup"}, setup_err, 0);
    check(hold_err == 0, {name, " R4 hold"}, hold_err, 0);
    check(sup_err == 0, {name, " R2 supply before pulse"}, sup_err, 0);
    check(fv_err == 0, {name, " R2 supply drop before final"}, fv_err, 0);
    check(ce_n && oe_n && pgm_n && !drive && !vpp, {name, " R1 idle after run"},
          int'({ce_n, oe_n, pgm_n, drive, vpp}), 5'b11100);
  endtask

  initial begin
    fresh_device();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ce_n && oe_n && pgm_n, "R1 strobes high", int'({ce_n, oe_n, pgm_n}), 7);
    check(!drive && !vpp && !vcc, "R1 bus and supplies", int'({drive, vpp, vcc}), 0);
    check(!done && !pass && !fail, "R1 results clear", int'({done, pass, fail}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(ce_n && pgm_n && !vpp, "R1 idle without start", int'({ce_n, pgm_n, vpp}), 6);

    // A: words need 1..4 pulses, all good
    fresh_device();
    for (int a = 0; a < NW; a++) need[a] = (a % 4) + 1;
    run("A", 1'b1);
    for (int a = 0; a < NW; a++) begin
      check(pc[a] == need[a], $sformatf("A R5 pulses word %0d", a), pc[a], need[a]);
      check(mem[a] == tgt(a), $sformatf("A R5 data word %0d", a), int'(mem[a]), int'(tgt(a)));
    end
    check(fv_seen == 1, "A R8 final pass entered", fv_seen, 1);

    // B: word 3 never takes
    fresh_device();
    need[3] = MAXP + 1;
    run("B", 1'b0);
    check(pc[3] == MAXP, "B R6 pulse limit", pc[3], MAXP);
    for (int a = 4; a < NW; a++)
      check(pc[a] == 0, $sformatf("B R6 no pulse word %0d", a), pc[a], 0);
    check(pc[0] == 1, "B R5 restart at word 0", pc[0], 1);
    check(fv_seen == 0, "B R6 no final pass", fv_seen, 0);

    // C: word 2 has a cleared cell where the target needs a 1
    fresh_device();
    mem[2] = 16'hFFFF & ~(tgt(2) & (~tgt(2) + 16'd1));
    run("C", 1'b0);
    check(pc[2] == 1, "C R7 single pulse", pc[2], 1);
    check(pc[3] == 0, "C R7 stopped", pc[3], 0);

    // D: word 5 misreads only at normal supply
    fresh_device();
    for (int a = 0; a < NW; a++) need[a] = 2;
    weak_en = 1'b1;
    weak_a = 3'd5;
    run("D", 1'b0);
    for (int a = 0; a < NW; a++)
      check(pc[a] == 2, $sformatf("D R8 pulses word %0d", a), pc[a], 2);
    check(fv_seen == 1, "D R8 final pass entered", fv_seen, 1);

    // E: clean device again passes after a failed run
    fresh_device();
    run("E", 1'b1);
    check(pulses == NW, "E R5 one pulse per word", pulses, NW);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule